// File: doc/BRIEF.md
# Shift Rotate Unit with Carry

This block is a single-operand shift and rotate stage for a 16-bit processor datapath. Each cycle it takes an operand, the incoming carry flag, a width select and a 3-bit operation code. It returns the shifted, rotated, swapped or sign-extended value together with new carry, zero and negative flags. The operations are logical right shift, arithmetic right shift, left shift, rotate right through carry, exchange of the two bytes, and sign extension of the low byte into the upper byte.

The width select applies to the four shift and rotate operations. When it is 1, only the low 8 bits take part, bit 7 acts as the most significant bit, and the upper result byte is forced to zero. The byte exchange and sign extension always work on the full word and never change the carry. A parameter chooses between a purely combinational output and one register stage. The default is the registered stage, which gives one cycle of latency.

Top module: `shift_rot_unit`

## Requirements
- R1: op_i = 3'b000 (logical right) gives result = operand shifted down one place with 0 entering the MSB; carry_o = old bit 0.
- R2: op_i = 3'b001 (arithmetic right) gives result = operand shifted down one place with the MSB kept at its old value; carry_o = old bit 0.
- R3: op_i = 3'b010 (left) gives result = operand shifted up one place with 0 entering bit 0; carry_o = old MSB.
- R4: op_i = 3'b011 (rotate right through carry) gives result = operand shifted down one place with carry_i entering the MSB; carry_o = old bit 0.
- R5: With byte_i = 1 and op_i[2] = 0, the R1 to R4 rules apply to bits 7:0 only, with bit 7 as the MSB. Result bits 15:8 are 0.
- R6: op_i = 3'b100 returns {operand[7:0], operand[15:8]}.
- R7: op_i = 3'b101 returns bit 7 of the operand copied into bits 15:8, with bits 7:0 unchanged.
- R8: For op_i[2] = 1, carry_o equals carry_i, and byte_i has no effect on the result or the flags.
- R9: zero_o is 1 exactly when the result is all zeros at the active width. That width is 8 bits for a shift in byte mode and 16 bits otherwise.
- R10: neg_o equals the MSB of the result at the active width (bit 7 or bit 15).
- R11: op_i = 3'b110 and 3'b111 return the operand unchanged, with carry_o = carry_i and the flags taken at word width.
- R12: With the default REG_OUT = 1, every output reflects the inputs of the previous rising clock edge, and all outputs are 0 while rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| operand_i | input | 16 | Operand value |
| carry_i | input | 1 | Incoming carry flag |
| byte_i | input | 1 | 0 selects word width, 1 selects byte width |
| op_i | input | 3 | Operation code |
| result_o | output | 16 | Operation result |
| carry_o | output | 1 | Updated carry flag |
| zero_o | output | 1 | Result is zero at the active width |
| neg_o | output | 1 | MSB of the result at the active width |

## Verification
The functions most likely to collide in one cycle are the carry injection of the rotate and the byte-width narrowing. A rotate in byte mode with carry_i = 1 must put the carry into bit 7, not bit 15, and must take the new carry from bit 0 while clearing the upper byte. This case is driven from the vector table, with upper-byte patterns chosen so that a wrong lane or missing masking changes the result or the flags. The same table pairs byte_i = 1 with the byte exchange and sign-extend codes, to show that the width bit reaches neither the value nor the flag width for those operations.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {
    OP_SHR  = 3'b000,
    OP_SAR  = 3'b001,
    OP_SHL  = 3'b010,
    OP_RRC  = 3'b011,
    OP_SWP  = 3'b100,
    OP_SXT  = 3'b101,
    OP_RSV6 = 3'b110,
    OP_RSV7 = 3'b111
  } srs_op_e;
endpackage

// File: rtl/srs_shift_core.sv
module srs_shift_core #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              cin_i,
  input  logic              narrow_i,
  input  logic [1:0]        sel_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] lane_res [2];
  logic              lane_c   [2];

  // lane 0: full word, lane 1: low half
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int W = (g == 0) ? DATA_W : HALF_W;
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         c;
    assign x = a_i[W-1:0];
    always_comb begin
      case (sel_i)
        2'b00: begin y = {1'b0, x[W-1:1]};   c = x[0];   end
        2'b01: begin y = {x[W-1], x[W-1:1]}; c = x[0];   end
        2'b10: begin y = {x[W-2:0], 1'b0};   c = x[W-1]; end
        default: begin y = {cin_i, x[W-1:1]}; c = x[0];  end
      endcase
    end
    assign lane_res[g] = DATA_W'(y);
    assign lane_c[g]   = c;
  end

  assign res_o  = narrow_i ? lane_res[1] : lane_res[0];
  assign cout_o = narrow_i ? lane_c[1]   : lane_c[0];
endmodule

// File: rtl/srs_byte_ops.sv
module srs_byte_ops #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              sxt_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] extended;

  assign swapped  = {a_i[HALF_W-1:0], a_i[DATA_W-1:HALF_W]};
  assign extended = {{HALF_W{a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
  assign res_o    = sxt_i ? extended : swapped;
endmodule

// File: rtl/srs_flags.sv
module srs_flags #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              narrow_i,
  output logic              zero_o,
  output logic              neg_o
);
  localparam int HALF_W = DATA_W / 2;

  assign zero_o = narrow_i ? (res_i[HALF_W-1:0] == '0) : (res_i == '0);
  assign neg_o  = narrow_i ? res_i[HALF_W-1] : res_i[DATA_W-1];
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import srs_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  input  logic              byte_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              neg_o
);
  localparam int HALF_W = DATA_W / 2;

  srs_op_e           op;
  logic              is_shift;
  logic              narrow;
  logic [DATA_W-1:0] sh_res;
  logic              sh_c;
  logic [DATA_W-1:0] bo_res;
  logic [DATA_W-1:0] res_d;
  logic              c_d;
  logic              z_d;
  logic              n_d;

  assign op       = srs_op_e'(op_i);
  assign is_shift = ~op_i[2];
  assign narrow   = is_shift & byte_i;

  srs_shift_core #(.DATA_W(DATA_W)) u_shift (
    .a_i      (operand_i),
    .cin_i    (carry_i),
    .narrow_i (narrow),
    .sel_i    (op_i[1:0]),
    .res_o    (sh_res),
    .cout_o   (sh_c)
  );

  srs_byte_ops #(.DATA_W(DATA_W)) u_bytes (
    .a_i   (operand_i),
    .sxt_i (op_i[0]),
    .res_o (bo_res)
  );

  always_comb begin
    unique case (op)
      OP_SWP, OP_SXT:   begin res_d = bo_res;    c_d = carry_i; end
      OP_RSV6, OP_RSV7: begin res_d = operand_i; c_d = carry_i; end
      default:          begin res_d = sh_res;    c_d = sh_c;    end
    endcase
  end

  srs_flags #(.DATA_W(DATA_W)) u_flags (
    .res_i    (res_d),
    .narrow_i (narrow),
    .zero_o   (z_d),
    .neg_o    (n_d)
  );

  if (REG_OUT) begin : g_reg
    logic seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        result_o <= '0;
        carry_o  <= 1'b0;
        zero_o   <= 1'b0;
        neg_o    <= 1'b0;
        seen_q   <= 1'b0;
      end else begin
        result_o <= res_d;
        carry_o  <= c_d;
        zero_o   <= z_d;
        neg_o    <= n_d;
        seen_q   <= 1'b1;
      end
    end

    // R1
    shr_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && $past(op_i == OP_SHR && !byte_i) |-> !result_o[DATA_W-1]);

    // R5
    byte_upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && $past(byte_i && !op_i[2]) |-> result_o[DATA_W-1:HALF_W] == '0);

    // R6
    swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && $past(op_i == OP_SWP) |->
        result_o == {$past(operand_i[HALF_W-1:0]), $past(operand_i[DATA_W-1:HALF_W])});

    // R8
    carry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && $past(op_i[2]) |-> carry_o == $past(carry_i));

    // R9
    zero_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && $past(op_i[2] || !byte_i) |-> zero_o == (result_o == '0));

    // R10
    neg_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q |-> neg_o == ($past(byte_i && !op_i[2]) ? result_o[HALF_W-1]
                                                     : result_o[DATA_W-1]));
  end else begin : g_comb
    assign result_o = res_d;
    assign carry_o  = c_d;
    assign zero_o   = z_d;
    assign neg_o    = n_d;
  end
endmodule

// File: tb/sim_shift_rot_unit.sv
`timescale 1ns/1ps
module sim_shift_rot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] operand;
  logic        cin;
  logic        bsel;
  logic [2:0]  op;
  logic [15:0] result;
  logic        cout, zf, nf;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  shift_rot_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .operand_i(operand), .carry_i(cin),
    .byte_i(bsel), .op_i(op), .result_o(result), .carry_o(cout),
    .zero_o(zf), .neg_o(nf)
  );

  // {op, byte, cin, operand, exp_result, exp_c, exp_z, exp_n}
  localparam int NV = 17;
  localparam logic [39:0] VEC [NV] = '{
    {3'b000, 1'b0, 1'b0, 16'h8001, 16'h4000, 1'b1, 1'b0, 1'b0}, // R1
    {3'b000, 1'b0, 1'b1, 16'h0001, 16'h0000, 1'b1, 1'b1, 1'b0}, // R1 R9
    {3'b001, 1'b0, 1'b0, 16'h8001, 16'hC000, 1'b1, 1'b0, 1'b1}, // R2
    {3'b010, 1'b0, 1'b0, 16'h8001, 16'h0002, 1'b1, 1'b0, 1'b0}, // R3
    {3'b010, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0}, // R3 R9
    {3'b011, 1'b0, 1'b1, 16'h0001, 16'h8000, 1'b1, 1'b0, 1'b1}, // R4
    {3'b011, 1'b0, 1'b0, 16'h0002, 16'h0001, 1'b0, 1'b0, 1'b0}, // R4
    {3'b000, 1'b1, 1'b0, 16'hAB01, 16'h0000, 1'b1, 1'b1, 1'b0}, // R5
    {3'b001, 1'b1, 1'b0, 16'hFF81, 16'h00C0, 1'b1, 1'b0, 1'b1}, // R5 R10
    {3'b010, 1'b1, 1'b0, 16'h1280, 16'h0000, 1'b1, 1'b1, 1'b0}, // R5 R9
    {3'b011, 1'b1, 1'b1, 16'hFF00, 16'h0080, 1'b0, 1'b0, 1'b1}, // R5 R4
    {3'b100, 1'b0, 1'b1, 16'h12F0, 16'hF012, 1'b1, 1'b0, 1'b1}, // R6
    {3'b101, 1'b0, 1'b0, 16'h1280, 16'hFF80, 1'b0, 1'b0, 1'b1}, // R7
    {3'b101, 1'b0, 1'b0, 16'hFF7F, 16'h007F, 1'b0, 1'b0, 1'b0}, // R7
    {3'b100, 1'b1, 1'b0, 16'h00AB, 16'hAB00, 1'b0, 1'b0, 1'b1}, // R8
    {3'b101, 1'b1, 1'b1, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0}, // R8
    {3'b110, 1'b0, 1'b1, 16'h1234, 16'h1234, 1'b1, 1'b0, 1'b0}  // R11
  };

  function automatic string tag_of(logic [2:0] o, logic b);
    if (o[2] && b && o != 3'b110 && o != 3'b111) return "R8";
    if (!o[2] && b) return "R5";
    case (o)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b011:  return "R4";
      3'b100:  return "R6";
      3'b101:  return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] o, logic b, logic c, logic [15:0] a);
    op = o; bsel = b; cin = c; operand = a;
  endtask

  initial begin
    drive(3'b011, 1'b0, 1'b1, 16'h5A5A);
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check("R12", "reset result", result, 16'h0000);
    check("R12", "reset flags", {13'd0, cout, zf, nf}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      string t;
      v = VEC[i];
      drive(v[39:37], v[36], v[35], v[34:19]);
      @(posedge clk);
      #1;
      t = tag_of(v[39:37], v[36]);
      check(t, "result", result, v[18:3]);
      check(t, "carry", {15'd0, cout}, {15'd0, v[2]});
      check("R9", "zero", {15'd0, zf}, {15'd0, v[1]});
      check("R10", "neg", {15'd0, nf}, {15'd0, v[0]});
    end

    // R11 code 111, carry held low
    drive(3'b111, 1'b1, 1'b0, 16'h8000);
    @(posedge clk); #1;
    check("R11", "result", result, 16'h8000);
    check("R11", "carry/zero/neg", {13'd0, cout, zf, nf}, 16'h0001);

    // R12 output holds until the next edge
    drive(3'b010, 1'b0, 1'b0, 16'h4000);
    @(posedge clk); #1;
    check("R12", "after edge", result, 16'h8000);
    drive(3'b000, 1'b0, 1'b0, 16'h0002);
    #1;
    check("R12", "before edge", result, 16'h8000);
    @(posedge clk); #1;
    check("R12", "next edge", result, 16'h0001);

    // R10 byte negative with upper bits set in operand
    drive(3'b010, 1'b1, 1'b0, 16'h8040);
    @(posedge clk); #1;
    check("R10", "byte neg", {13'd0, cout, zf, nf}, 16'h0001);
    check("R5", "byte shl", result, 16'h0080);

    // R12 asynchronous reset clears outputs
    #1 rst_n = 1'b0;
    #1;
    check("R12", "async reset", {cout, zf, nf, result[12:0]}, 16'h0000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule